// File: doc/BRIEF.md
# Background Subtraction Binarizer

This block removes a static scene from a live camera stream and turns what remains into a black-and-white mask. Two 8-bit pixel streams arrive together on the same cycle. One carries the current frame. The other carries a stored frame of the same empty scene. The block subtracts the stored sample from the live one and clamps negative results to zero. It then decides whether the pixel is foreground and writes either full scale (255) or black (0). It works directly on raw colour-mosaic samples, so no demosaicing step is needed ahead of it.

Two decision rules are available. In threshold mode a pixel is foreground when its difference is strictly greater than a programmable level. In window mode a pixel is foreground when its difference lies inside an inclusive band set by a lower and an upper bound. The rule and its levels are captured once, on the first pixel of each frame, so software may rewrite them at any time without corrupting the frame in flight. The reference frame is 102 columns by 150 rows. The block itself has no notion of frame size: a frame ends at the pixel tagged as last.

A small controller tracks whether a frame is open at the input and whether results are still in the pipeline. It has three states:
- `ST_IDLE`: no frame open and the pipeline is empty.
- `ST_STREAM`: a frame is open at the input.
- `ST_DRAIN`: the last input pixel has been accepted but its result has not yet left.

It moves between them as follows:
- `ST_IDLE` to `ST_STREAM` on a first pixel that is not last.
- `ST_IDLE` to `ST_DRAIN` on a one-pixel frame.
- `ST_STREAM` to `ST_DRAIN` on the last input pixel.
- `ST_DRAIN` to `ST_STREAM` when a new multi-pixel frame starts.
- `ST_DRAIN` back to `ST_DRAIN` when a new one-pixel frame starts.
- `ST_DRAIN` to `ST_IDLE` when the final result is emitted and no further last-pixel is in flight.

The `busy` output is high in every state except `ST_IDLE`. An external timer can therefore measure processing time per frame.

Top module: `bgsub_binarizer`

## Requirements
- R1: An input pixel accepted with `in_valid` high on clock edge k produces its result with `out_valid` high right after edge k+1 (two register stages). `out_valid` is low after reset and in every cycle that has no matching input.
- R2: Whenever `out_valid` is high, `out_px` is either 0 or 255. `out_px` is 0 whenever `out_valid` is low.
- R3: The difference is `live_px - bg_px`. When `live_px` is less than or equal to `bg_px`, the difference is 0, so the result is 0 in threshold mode.
- R4: With `cfg_window` captured as 0 (threshold mode), the result is 255 exactly when the difference is strictly greater than the captured `cfg_thresh`. Otherwise it is 0.
- R5: With `cfg_window` captured as 1 (window mode), the result is 255 exactly when `cfg_lo <= difference <= cfg_hi`, both bounds inclusive. Otherwise it is 0.
- R6: `cfg_window`, `cfg_thresh`, `cfg_lo` and `cfg_hi` are captured only on the first pixel of a frame. A first pixel is an accepted pixel that arrives while no frame is open at the input. Changes made later in the frame have no effect on that frame's results.
- R7: `busy` is low after reset. It is high from the cycle after the first pixel of a frame is accepted.
- R8: `busy` falls in the cycle after the result that carries `out_eof` is output, unless another frame has already started. It stays high across back-to-back frames.
- R9: `out_eof` is high together with the result of the pixel that had `in_eof` high, and low on every other output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Live and background samples are present this cycle |
| in_eof | input | 1 | This pixel is the last of its frame |
| live_px | input | 8 | Sample from the current frame |
| bg_px | input | 8 | Sample from the stored empty-scene frame, same position |
| cfg_window | input | 1 | 0 selects threshold mode, 1 selects window mode |
| cfg_thresh | input | 8 | Threshold level, strictly exceeded for foreground |
| cfg_lo | input | 8 | Window lower bound, inclusive |
| cfg_hi | input | 8 | Window upper bound, inclusive |
| out_valid | output | 1 | Result pixel present |
| out_px | output | 8 | Binary result, 0 or 255 |
| out_eof | output | 1 | Result belongs to the last pixel of its frame |
| busy | output | 1 | A frame is being processed |

## Verification
The bench targets the values right at each decision edge:
- A difference exactly equal to the threshold must give black. A design using greater-or-equal would return 255 there.
- Differences at, one below and one above each window bound must be classified correctly. An exclusive compare would drop the bound values.
- A live sample darker than the background must clamp to zero. A design without the clamp would wrap around and mark the pixel bright.

The bench also rewrites the mode and levels in the middle of a frame, so a design that reads them live would flip results within that frame. Back-to-back frames, including two one-pixel frames in a row, check that `busy` neither drops early nor stays high after the last result.

// File: rtl/bgsub_pkg.sv
package bgsub_pkg;

    // Frame-level controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_DRAIN  = 2'd2
    } frame_state_t;

endpackage

// File: rtl/bgsub_diff_stage.sv
// Stage 1: clamped difference of live and background samples.
module bgsub_diff_stage #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_eof,
    input  logic [PIX_W-1:0] live_px,
    input  logic [PIX_W-1:0] bg_px,
    output logic             s1_valid,
    output logic             s1_eof,
    output logic [PIX_W-1:0] s1_diff
);

    logic [PIX_W-1:0] diff_d;

    always_comb begin
        if (live_px > bg_px) diff_d = live_px - bg_px;
        else                 diff_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_eof   <= 1'b0;
            s1_diff  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_eof   <= in_valid && in_eof;
            s1_diff  <= in_valid ? diff_d : '0;
        end
    end

    AST_NEG_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (live_px <= bg_px)) |=> (s1_diff == '0)); // R3

endmodule

// File: rtl/bgsub_decide_stage.sv
// Stage 2: per-frame configuration snapshot and binary decision.
module bgsub_decide_stage #(
    parameter int PIX_W          = 8,
    parameter bit WINDOW_MODE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_window,
    input  logic [PIX_W-1:0] cfg_thresh,
    input  logic [PIX_W-1:0] cfg_lo,
    input  logic [PIX_W-1:0] cfg_hi,
    input  logic             s1_valid,
    input  logic             s1_eof,
    input  logic [PIX_W-1:0] s1_diff,
    output logic             out_valid,
    output logic             out_eof,
    output logic [PIX_W-1:0] out_px
);

    localparam logic [PIX_W-1:0] FULL_SCALE = {PIX_W{1'b1}};

    logic             win_q;
    logic [PIX_W-1:0] thr_q, lo_q, hi_q;
    logic             hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
            thr_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (cfg_load) begin
            win_q <= cfg_window;
            thr_q <= cfg_thresh;
            lo_q  <= cfg_lo;
            hi_q  <= cfg_hi;
        end
    end

    generate
        if (WINDOW_MODE_EN) begin : g_window
            always_comb begin
                if (win_q) hit = (s1_diff >= lo_q) && (s1_diff <= hi_q);
                else       hit = (s1_diff > thr_q);
            end
        end else begin : g_thresh_only
            logic unused_cfg;
            assign unused_cfg = win_q ^ (^lo_q) ^ (^hi_q);
            always_comb hit = (s1_diff > thr_q);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_eof   <= 1'b0;
            out_px    <= '0;
        end else begin
            out_valid <= s1_valid;
            out_eof   <= s1_eof;
            out_px    <= (s1_valid && hit) ? FULL_SCALE : '0;
        end
    end

    AST_OUT_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_px == '0) || (out_valid && (out_px == FULL_SCALE))); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ($stable(thr_q) && $stable(win_q) && $stable(lo_q) && $stable(hi_q))); // R6
    AST_THRESH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !win_q && (s1_diff > thr_q)) |=> (out_px == FULL_SCALE)); // R4
    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid); // R1

endmodule

// File: rtl/bgsub_frame_ctrl.sv
// Frame tracking: first-pixel detection and busy flag.
module bgsub_frame_ctrl
    import bgsub_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_eof,
    input  logic s1_last,
    input  logic out_last,
    output logic frame_start,
    output logic busy
);

    frame_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) state_d = in_eof ? ST_DRAIN : ST_STREAM;
            end
            ST_STREAM: begin
                if (in_valid && in_eof) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (in_valid)                   state_d = in_eof ? ST_DRAIN : ST_STREAM;
                else if (out_last && !s1_last)  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        frame_start = in_valid && (state_q != ST_STREAM);
        busy        = (state_q != ST_IDLE);
    end

    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && in_valid) |=> busy); // R7
    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(out_last)); // R8

endmodule

// File: rtl/bgsub_binarizer.sv
module bgsub_binarizer #(
    parameter int PIX_W          = 8,
    parameter bit WINDOW_MODE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_eof,
    input  logic [PIX_W-1:0] live_px,
    input  logic [PIX_W-1:0] bg_px,
    input  logic             cfg_window,
    input  logic [PIX_W-1:0] cfg_thresh,
    input  logic [PIX_W-1:0] cfg_lo,
    input  logic [PIX_W-1:0] cfg_hi,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_px,
    output logic             out_eof,
    output logic             busy
);

    logic             s1_valid, s1_eof;
    logic [PIX_W-1:0] s1_diff;
    logic             frame_start;

    bgsub_diff_stage #(.PIX_W(PIX_W)) u_diff (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_eof   (in_eof),
        .live_px  (live_px),
        .bg_px    (bg_px),
        .s1_valid (s1_valid),
        .s1_eof   (s1_eof),
        .s1_diff  (s1_diff)
    );

    bgsub_decide_stage #(.PIX_W(PIX_W), .WINDOW_MODE_EN(WINDOW_MODE_EN)) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (frame_start),
        .cfg_window (cfg_window),
        .cfg_thresh (cfg_thresh),
        .cfg_lo     (cfg_lo),
        .cfg_hi     (cfg_hi),
        .s1_valid   (s1_valid),
        .s1_eof     (s1_eof),
        .s1_diff    (s1_diff),
        .out_valid  (out_valid),
        .out_eof    (out_eof),
        .out_px     (out_px)
    );

    bgsub_frame_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_eof      (in_eof),
        .s1_last     (s1_valid && s1_eof),
        .out_last    (out_valid && out_eof),
        .frame_start (frame_start),
        .busy        (busy)
    );

    AST_EOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid); // R9

endmodule

// File: tb/bgsub_binarizer_bench.sv
module bgsub_binarizer_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_eof, cfg_window;
    logic [7:0] live_px, bg_px, cfg_thresh, cfg_lo, cfg_hi;
    logic       out_valid, out_eof, busy;
    logic [7:0] out_px;

    always #4 clk = ~clk;

    bgsub_binarizer u_bgsub_binarizer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
        .live_px(live_px), .bg_px(bg_px), .cfg_window(cfg_window),
        .cfg_thresh(cfg_thresh), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .out_valid(out_valid), .out_px(out_px), .out_eof(out_eof), .busy(busy)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state
    int    q_v[$];
    int    q_px[$];
    int    q_eof[$];
    string q_tag[$];
    bit    frame_open = 1'b0;
    bit    s_win = 1'b0;
    int    s_thr = 0, s_lo = 0, s_hi = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input int live, input int bg, input bit eof);
        int    d;
        int    e;
        string tag;
        bit    busy_exp;
        in_valid = v;
        in_eof   = eof;
        live_px  = live[7:0];
        bg_px    = bg[7:0];
        if (v && !frame_open) begin
            s_win = cfg_window;
            s_thr = cfg_thresh;
            s_lo  = cfg_lo;
            s_hi  = cfg_hi;
        end
        d = live - bg;
        if (d < 0) d = 0;
        if (s_win) begin
            e   = (d >= s_lo && d <= s_hi) ? 255 : 0;
            tag = "R5 window result";
        end else begin
            e   = (d > s_thr) ? 255 : 0;
            tag = "R4 threshold result";
        end
        if (live <= bg) tag = {tag, " R3 clamp"};
        if (v) frame_open = !eof;
        q_v.push_back(v);
        q_px.push_back(v ? e : 0);
        q_eof.push_back(v && eof);
        q_tag.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        busy_exp = frame_open;
        foreach (q_eof[i]) if (q_eof[i] != 0) busy_exp = 1'b1;
        check(busy == busy_exp, "R7/R8 busy", busy, busy_exp);
        if (q_v.size() >= 2) begin
            int    ev, ep, ee;
            string et;
            ev = q_v.pop_front();
            ep = q_px.pop_front();
            ee = q_eof.pop_front();
            et = q_tag.pop_front();
            check(out_valid == ev[0], "R1 out_valid timing", out_valid, ev);
            check(out_px == ep[7:0], ev != 0 ? et : "R2 idle output zero", out_px, ep);
            check(out_eof == ee[0], "R9 out_eof", out_eof, ee);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rng;
        rst_n = 1'b0; in_valid = 1'b0; in_eof = 1'b0;
        live_px = '0; bg_px = '0;
        cfg_window = 1'b0; cfg_thresh = 8'd20; cfg_lo = 8'd10; cfg_hi = 8'd30;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        check(out_px == 8'd0, "R2 reset out_px", out_px, 0);
        check(busy == 1'b0, "R7 reset busy", busy, 0);

        // Threshold mode: boundary, above, negative, full scale, zero, gap
        cyc(1, 100, 80, 0);   // diff 20 == thr -> 0 (R4)
        cyc(1, 101, 80, 0);   // diff 21 -> 255 (R4)
        cyc(0, 0, 0, 0);      // gap inside frame
        cyc(1, 50, 90, 0);    // negative -> 0 (R3)
        cyc(1, 255, 0, 0);    // full -> 255
        cyc(1, 0, 0, 1);      // last pixel
        idle(4);

        // Window mode with mid-frame reconfiguration (R5, R6)
        cfg_window = 1'b1; cfg_lo = 8'd10; cfg_hi = 8'd30;
        cyc(1, 59, 50, 0);    // 9 -> 0
        cfg_window = 1'b0; cfg_thresh = 8'd0; cfg_lo = 8'd0; cfg_hi = 8'd255;
        cyc(1, 60, 50, 0);    // 10 -> 255
        cyc(1, 80, 50, 0);    // 30 -> 255
        cyc(1, 81, 50, 0);    // 31 -> 0
        cyc(1, 70, 50, 0);    // 20 -> 255
        cyc(1, 40, 50, 1);    // negative -> 0
        idle(3);

        // Back-to-back frames, including one-pixel frames (R8, R9)
        cfg_window = 1'b0; cfg_thresh = 8'd5;
        cyc(1, 10, 0, 0);
        cyc(1, 5, 0, 0);
        cyc(1, 6, 0, 1);
        cfg_thresh = 8'd200;
        cyc(1, 10, 0, 0);     // new frame, thr 200 -> 0
        cyc(1, 250, 0, 1);
        cfg_thresh = 8'd0;
        cyc(1, 1, 0, 1);      // one-pixel frame
        cfg_window = 1'b1; cfg_lo = 8'd3; cfg_hi = 8'd3;
        cyc(1, 3, 0, 1);      // another one-pixel frame
        idle(4);

        // Full reference-size frame, 102 x 150, pseudo-random samples
        cfg_window = 1'b0; cfg_thresh = 8'd100;
        rng = 32'h1234_5678;
        for (int p = 0; p < 102 * 150; p++) begin
            int a, b;
            rng = rng * 32'd1103515245 + 32'd12345;
            a = int'(rng[23:16]);
            b = int'(rng[15:8]);
            if (p % 37 == 5) cyc(0, 0, 0, 0);
            cyc(1, a, b, p == 102 * 150 - 1);
        end
        idle(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule